// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decode

This block counts qualifying edges on an external count input and presents the count as ten one-hot lines plus a carry line. The count is held in a five-stage twisted-ring register. Each of the ten legal ring patterns maps to exactly one output line, and each line is formed from just two neighbouring ring bits. The carry line stays high during the first half of each decade, so it completes one period for every ten counts and can drive the count input of a following stage.

The count and inhibit inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer and a previous-sample register, and the block detects its rising and falling edges. There are two ways to advance the count. The first is a rising count level while inhibit is low. The second is a falling inhibit level while the count level is high, so inhibit also works as an inverted clock. A synchronous active-high reset overrides everything else and returns the counter to state zero.

Top module: `johnson_decade_counter`

## Requirements
- R1: The reset is synchronous and active high. After any clock edge that samples reset high, the decoded output is 10'b0000000001 (line 0 high) and carry is high.
- R2: Exactly one decoded line is high at all times after reset. The ring holds only its ten legal patterns, and if an illegal pattern appears it is replaced by state zero on the next advance.
- R3: A rising edge on the count input while inhibit is low advances the count by one. Bit n of the output is high for count n. Count 9 wraps to count 0.
- R4: A falling edge on the count input leaves the count unchanged.
- R5: A rising edge on the count input while inhibit is high leaves the count unchanged.
- R6: A falling edge on inhibit while the count input is high advances the count by one.
- R7: A rising edge on inhibit leaves the count unchanged. A falling edge on inhibit while the count input is low also leaves the count unchanged.
- R8: Carry is high for counts 0 to 4 and low for counts 5 to 9.
- R9: Suppose an input is changed between rising clock edges. The first rising edge after the change is edge 1. The decoded outputs still show the old count after edge 2 and show the new count after edge 3.
- R10: An input level that is held steady while reset is released causes no count.
- R11: Edges on the count input that occur while reset is high cause no count, either during reset or after it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 1 | Asynchronous count input |
| inh_in | input | 1 | Asynchronous inhibit input; its falling edge also acts as an inverted count |
| dec_out | output | 10 | One-hot decoded count; bit n is high for count n |
| carry_out | output | 1 | High for counts 0 to 4 |

## Verification
The assertions rely on two assumptions about the inputs:
- Each level of count and inhibit is held for at least three system clocks, so every change reaches the edge detector as a single edge.
- The two inputs never change in the same clock.

The stimulus meets both. It changes one input at a time and holds each new level for four clocks before the scoreboard entry is taken. The latency check is the one exception: it samples at every clock after a single change on the count input.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

    parameter int unsigned JDC_STAGES = 5;
    localparam int unsigned JDC_OUTS  = 2 * JDC_STAGES;

    typedef logic [JDC_STAGES-1:0] ring_t;
    typedef logic [JDC_OUTS-1:0]   onehot_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_t;

    // A legal twisted-ring pattern has at most one boundary between neighbouring bits.
    function automatic logic ring_legal(ring_t r);
        int unsigned bounds;
        bounds = 0;
        for (int i = 0; i < int'(JDC_STAGES) - 1; i++) begin
            if (r[i] != r[i+1]) bounds++;
        end
        return (bounds <= 1);
    endfunction

    // One advance: shift left and feed the inverted last stage into bit 0.
    // Any illegal pattern is replaced by state zero.
    function automatic ring_t ring_step(ring_t r);
        if (!ring_legal(r)) return '0;
        return {r[JDC_STAGES-2:0], ~r[JDC_STAGES-1]};
    endfunction

endpackage

// File: rtl/jdc_edge_sync.sv
module jdc_edge_sync
    import jdc_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t ev
);
    localparam int unsigned TOP = SYNC_DEPTH - 1;

    logic [SYNC_DEPTH-1:0] sync_q;
    logic                  prev_q;

    // While reset is high, every stage loads the raw level. A level that is
    // steady across the release therefore produces no edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {SYNC_DEPTH{din}};
            prev_q <= din;
        end else begin
            sync_q <= {sync_q[SYNC_DEPTH-2:0], din};
            prev_q <= sync_q[TOP];
        end
    end

    always_comb begin
        ev.level = sync_q[TOP];
        ev.rise  = sync_q[TOP] & ~prev_q;
        ev.fall  = ~sync_q[TOP] & prev_q;
    end

    // R10: no edge is reported in the cycle just after reset
    a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ev.rise && !ev.fall));

    // R9: an edge lasts a single cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (ev.rise || ev.fall) |=> (!ev.rise && !ev.fall));

endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
    import jdc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output ring_t ring
);
    always_ff @(posedge clk) begin
        if (rst)      ring <= '0;
        else if (adv) ring <= ring_step(ring);
    end

    // R1: reset leaves the ring in state zero
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ring == '0));

    // R2: only legal patterns are ever held
    a_r2_legal: assert property (@(posedge clk) disable iff (rst)
        ring_legal(ring));

endmodule

// File: rtl/jdc_decode.sv
module jdc_decode
    import jdc_pkg::*;
(
    input  ring_t   ring,
    output onehot_t dec,
    output logic    carry
);
    localparam int unsigned S = JDC_STAGES;

    assign dec[0] = ~ring[0] & ~ring[S-1];
    assign dec[S] =  ring[0] &  ring[S-1];

    // Each remaining line looks only at the boundary between two neighbouring bits.
    for (genvar k = 1; k < S; k++) begin : g_bound
        assign dec[k]   =  ring[k-1] & ~ring[k];
        assign dec[S+k] = ~ring[k-1] &  ring[k];
    end

    assign carry = ~ring[S-1];

endmodule

// File: rtl/johnson_decade_counter.sv
module johnson_decade_counter
    import jdc_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_in,
    input  logic                inh_in,
    output logic [JDC_OUTS-1:0] dec_out,
    output logic                carry_out
);
    edge_t cnt_ev;
    edge_t inh_ev;
    ring_t ring;
    logic  adv;

    jdc_edge_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_cnt_sync (
        .clk (clk),
        .rst (rst),
        .din (cnt_in),
        .ev  (cnt_ev)
    );

    jdc_edge_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_inh_sync (
        .clk (clk),
        .rst (rst),
        .din (inh_in),
        .ev  (inh_ev)
    );

    // Two ways to advance: count rises while inhibit is low, or inhibit falls
    // while count is high. Reset blocks both.
    assign adv = ~rst & ((cnt_ev.rise & ~inh_ev.level) | (inh_ev.fall & cnt_ev.level));

    jdc_ring u_ring (
        .clk  (clk),
        .rst  (rst),
        .adv  (adv),
        .ring (ring)
    );

    jdc_decode u_dec (
        .ring  (ring),
        .dec   (dec_out),
        .carry (carry_out)
    );

    // R2: exactly one decoded line is high
    a_r2_one_hot: assert property (@(posedge clk) disable iff (rst)
        $countones(dec_out) == 1);

    // R8: carry tracks the lower half of the decade
    a_r8_carry_half: assert property (@(posedge clk) disable iff (rst)
        carry_out == (|dec_out[JDC_STAGES-1:0]));

    // R3: an advance moves the active line
    a_r3_moves: assert property (@(posedge clk) disable iff (rst)
        adv |=> (dec_out != $past(dec_out)));

    // R3: the last line wraps to line 0
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && dec_out[JDC_OUTS-1]) |=> dec_out[0]);

    // R4: without an advance the count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(dec_out));

endmodule

// File: tb/sim_johnson_decade_counter.sv
module sim_johnson_decade_counter;
    import jdc_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cnt_in = 1'b0;
    logic                inh_in = 1'b0;
    logic [JDC_OUTS-1:0] dec_out;
    logic                carry_out;

    int total = 0;
    int bad   = 0;
    int m     = 0;
    bit done  = 1'b0;

    int    qn[$];
    string qt[$];

    always #10 clk = ~clk;   // 50 MHz

    johnson_decade_counter u0 (
        .clk       (clk),
        .rst       (rst),
        .cnt_in    (cnt_in),
        .inh_in    (inh_in),
        .dec_out   (dec_out),
        .carry_out (carry_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [JDC_OUTS-1:0] exp_line(int n);
        return JDC_OUTS'(1) << n;
    endfunction

    // monitor: pops expected counts and compares them with the outputs
    always @(negedge clk) begin
        while (qn.size() > 0) begin
            int    n;
            string t;
            n = qn.pop_front();
            t = qt.pop_front();
            chk(dec_out == exp_line(n), t, 32'(dec_out), 32'(exp_line(n)));
            chk($countones(dec_out) == 1, "R2 one-hot", 32'($countones(dec_out)), 32'd1);
            chk(carry_out == (n < 5), "R8 carry", 32'(carry_out), 32'(n < 5));
        end
    end

    task automatic push(input string tag);
        qn.push_back(m);
        qt.push_back(tag);
    endtask

    task automatic set_cnt(input bit v, input string tag);
        @(negedge clk);
        cnt_in = v;
        repeat (4) @(negedge clk);
        push(tag);
    endtask

    task automatic set_inh(input bit v, input string tag);
        @(negedge clk);
        inh_in = v;
        repeat (4) @(negedge clk);
        push(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        m = 0;
        push("R1 reset state");

        // R3 R8: ten counts through the whole decade and the wrap
        for (int i = 0; i < 10; i++) begin
            m = (m + 1) % 10;
            set_cnt(1'b1, "R3 count rise");
            set_cnt(1'b0, "R4 count fall");
        end

        // R7: inhibit rises, then R5: count rises while inhibited
        set_inh(1'b1, "R7 inhibit rise");
        set_cnt(1'b1, "R5 rise while inhibited");
        // R6: inhibit falls while count is high
        m = (m + 1) % 10;
        set_inh(1'b0, "R6 inhibit fall");
        set_cnt(1'b0, "R4 count fall");
        // R7: inhibit falls while count is low
        set_inh(1'b1, "R7 inhibit rise");
        set_inh(1'b0, "R7 inhibit fall with count low");

        // R9: exact latency of a count rise
        @(negedge clk);
        cnt_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(dec_out == exp_line(m), "R9 old count after edge 2", 32'(dec_out), 32'(exp_line(m)));
        @(negedge clk);
        m = (m + 1) % 10;
        chk(dec_out == exp_line(m), "R9 new count after edge 3", 32'(dec_out), 32'(exp_line(m)));
        set_cnt(1'b0, "R4 count fall");

        // R11: edges on count while reset is high
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        m = 0;
        chk(dec_out == exp_line(0), "R1 reset mid-count", 32'(dec_out), 32'(exp_line(0)));
        cnt_in = 1'b1;
        repeat (4) @(negedge clk);
        cnt_in = 1'b0;
        repeat (4) @(negedge clk);
        // R10: count held high across the release
        cnt_in = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        push("R11 R10 no count from reset window");

        // The counter still works after that sequence.
        set_cnt(1'b0, "R4 count fall");
        m = (m + 1) % 10;
        set_cnt(1'b1, "R3 count rise after reset");

        wait (qn.size() == 0);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule